// File: doc/BRIEF.md
# Randomized Sector Address Scrambler

This block sits between a small paged virtual memory and a flash card, and it translates sector numbers. The virtual memory holds 1 MB as 2048 sectors of 512 bytes, so a logical sector number is 11 bits wide. The card gives the block a much larger reserved region of 2^21 sectors (1 GB). That region starts at a fixed base sector. Sectors below the base are never touched, so they stay free for a separate partition.

The block spreads wear across the reserved region. A free-running pseudo-random generator runs all the time. On every restart, whether from a system reset or a new program load, the block latches a fresh 21-bit mask from that generator. For every read or write request, the block zero-extends the logical sector, XORs it with the mask and adds the base. Within one session the mapping is fixed, so the virtual memory behaves as ordinary storage. Each new session lands the 2048 sectors somewhere else inside the reserved region.

Requests enter on a valid/ready handshake that carries the sector number and a write flag. Translated requests leave on a second valid/ready handshake through a two-stage pipeline.

Top module: `sector_scrambler`

## Requirements
- R1: An accepted request with logical sector L leaves as physical sector BASE + ({10'b0, L} XOR M), where M is the 21-bit mask of the current session. The sum is formed in the full OUT_W-bit output width.
- R2: Every physical sector issued lies in the range BASE to BASE + 2^21 - 1. No sector below BASE is ever produced.
- R3: The mask is sampled from a free-running maximal-length 24-bit LFSR, which never holds zero. A restart that follows the previous one by a different number of cycles yields a different mask.
- R4: Reset acts as a restart. While rst_ni is low and in the first cycle after its release, req_ready_o is 0. Output valid is 0 from reset.
- R5: The mask does not change between restarts, so one logical sector maps to one physical sector for the whole session.
- R6: In any cycle where restart_i is 1, req_ready_o is 0 and no request is accepted. Requests accepted after that cycle use the new mask.
- R7: The write flag (1 = write, 0 = read) reaches phys_wr_o unchanged, together with its translated sector.
- R8: While phys_valid_o is 1 and phys_ready_i is 0, the output sector and flag hold their values. Results leave in acceptance order, with none lost or duplicated. The latency is two cycles.
- R9: With both pipeline stages full and phys_ready_i at 0, req_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Restart strobe; latches a new mask |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_sector_i | input | LOG_W | Logical sector number |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| phys_valid_o | output | 1 | Translated request valid |
| phys_ready_i | input | 1 | Downstream ready |
| phys_sector_o | output | OUT_W | Physical sector number |
| phys_wr_o | output | 1 | Write flag passed through |

## Verification
The mask is random and cannot be seen at the ports, so the bench has to find it out. After each restart, the first request it sends is for logical sector 0. The physical sector that comes back minus the base gives the mask. Every later prediction is built on that value, and each new mask is compared with the one before it. The hardest case to bring about is a restart that arrives while a request is being offered. The bench asserts the strobe with a request held valid, then checks that nothing was taken and that any stray output would find an empty scoreboard.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned LOG_W_D  = 11;
  localparam int unsigned MASK_W_D = 21;
  localparam int unsigned LFSR_W_D = 24;
  localparam int unsigned OUT_W_D  = 32;
  // feedback bits 23,22,21,16: x^24+x^23+x^22+x^17+1
  localparam logic [LFSR_W_D-1:0] TAPS_D = 24'hE1_0000;
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
  parameter int unsigned     W    = scr_pkg::LFSR_W_D,
  parameter logic [W-1:0]    TAPS = scr_pkg::TAPS_D,
  parameter logic [W-1:0]    SEED = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/scr_mask_ctl.sv
module scr_mask_ctl #(
  parameter int unsigned LFSR_W = scr_pkg::LFSR_W_D,
  parameter int unsigned MASK_W = scr_pkg::MASK_W_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [LFSR_W-1:0] rand_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              hold_o
);
  logic              pend_q;  // reset counts as a restart
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
      mask_q <= '0;
    end else if (restart_i || pend_q) begin
      pend_q <= 1'b0;
      mask_q <= rand_i[MASK_W-1:0];
    end
  end

  assign hold_o = restart_i | pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/scr_stage.sv
module scr_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready_o = ~vld_q | out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) dat_q <= in_data_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;
endmodule

// File: rtl/sector_scrambler.sv
module sector_scrambler #(
  parameter int unsigned LOG_W  = scr_pkg::LOG_W_D,
  parameter int unsigned MASK_W = scr_pkg::MASK_W_D,
  parameter int unsigned LFSR_W = scr_pkg::LFSR_W_D,
  parameter logic [LFSR_W-1:0] TAPS = scr_pkg::TAPS_D,
  parameter int unsigned OUT_W  = scr_pkg::OUT_W_D,
  parameter logic [OUT_W-1:0] BASE = 32'h0004_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [LOG_W-1:0] req_sector_i,
  input  logic             req_wr_i,
  output logic             phys_valid_o,
  input  logic             phys_ready_i,
  output logic [OUT_W-1:0] phys_sector_o,
  output logic             phys_wr_o
);
  localparam int unsigned S1_W = MASK_W + 1;
  localparam int unsigned S2_W = OUT_W + 1;

  logic [LFSR_W-1:0] rnd;
  logic [MASK_W-1:0] mask;
  logic              hold;

  scr_lfsr #(.W(LFSR_W), .TAPS(TAPS)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_o(rnd)
  );

  scr_mask_ctl #(.LFSR_W(LFSR_W), .MASK_W(MASK_W)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i),
    .rand_i(rnd), .mask_o(mask), .hold_o(hold)
  );

  // stage 1: scramble
  logic            s1_in_ready, s1_valid, s2_in_ready;
  logic [S1_W-1:0] s1_in, s1_q;
  logic [MASK_W-1:0] ext_sector;

  assign ext_sector = {{(MASK_W-LOG_W){1'b0}}, req_sector_i};
  assign s1_in      = {req_wr_i, ext_sector ^ mask};

  scr_stage #(.W(S1_W)) u_s1 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(req_valid_i & ~hold), .in_ready_o(s1_in_ready), .in_data_i(s1_in),
    .out_valid_o(s1_valid), .out_ready_i(s2_in_ready), .out_data_o(s1_q)
  );

  assign req_ready_o = s1_in_ready & ~hold;

  // stage 2: offset into reserved area
  logic [S2_W-1:0] s2_in, s2_q;

  assign s2_in = {s1_q[S1_W-1], BASE + {{(OUT_W-MASK_W){1'b0}}, s1_q[MASK_W-1:0]}};

  scr_stage #(.W(S2_W)) u_s2 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(s1_valid), .in_ready_o(s2_in_ready), .in_data_i(s2_in),
    .out_valid_o(phys_valid_o), .out_ready_i(phys_ready_i), .out_data_o(s2_q)
  );

  assign phys_wr_o     = s2_q[S2_W-1];
  assign phys_sector_o = s2_q[OUT_W-1:0];
endmodule

// File: rtl/scr_chk.sv
module scr_chk #(
  parameter int unsigned MASK_W = 21,
  parameter int unsigned LFSR_W = 24,
  parameter int unsigned OUT_W  = 32,
  parameter logic [OUT_W-1:0] BASE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              restart_i,
  input logic              req_ready_o,
  input logic              phys_valid_o,
  input logic              phys_ready_i,
  input logic [OUT_W-1:0]  phys_sector_o,
  input logic              phys_wr_o,
  input logic [MASK_W-1:0] mask,
  input logic              hold,
  input logic [LFSR_W-1:0] rnd
);
  localparam logic [OUT_W:0] LIMIT = {1'b0, BASE} + ({{OUT_W{1'b0}}, 1'b1} << MASK_W);

  a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_valid_o |-> ({1'b0, phys_sector_o} >= {1'b0, BASE}) && ({1'b0, phys_sector_o} < LIMIT));

  a_r3_lfsr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd != '0);

  a_r5_mask_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !hold) |=> $stable(mask));

  a_r6_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !req_ready_o);

  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phys_valid_o && !phys_ready_i) |=> phys_valid_o && $stable(phys_sector_o) && $stable(phys_wr_o));
endmodule

bind sector_scrambler scr_chk #(
  .MASK_W(MASK_W), .LFSR_W(LFSR_W), .OUT_W(OUT_W), .BASE(BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i), .req_ready_o(req_ready_o),
  .phys_valid_o(phys_valid_o), .phys_ready_i(phys_ready_i),
  .phys_sector_o(phys_sector_o), .phys_wr_o(phys_wr_o),
  .mask(mask), .hold(hold), .rnd(rnd)
);

// File: tb/sim_sector_scrambler.sv
module sim_sector_scrambler;
  localparam int unsigned LOG_W = 11;
  localparam int unsigned OUT_W = 32;
  localparam logic [OUT_W-1:0] BASE = 32'h0004_0000;
  localparam logic [OUT_W-1:0] SPAN = 32'h0020_0000;

  typedef struct packed { logic wr; logic [LOG_W-1:0] ls; logic learn; } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic restart = 1'b0, req_valid = 1'b0, req_ready, req_wr = 1'b0;
  logic [LOG_W-1:0] req_sector = '0;
  logic phys_valid, phys_ready = 1'b1, phys_wr;
  logic [OUT_W-1:0] phys_sector;

  int checks = 0, errors = 0;
  bit bp_on = 1'b0;
  item_t q[$];

  always #5 clk = ~clk;

  sector_scrambler #(.BASE(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_sector_i(req_sector), .req_wr_i(req_wr),
    .phys_valid_o(phys_valid), .phys_ready_i(phys_ready),
    .phys_sector_o(phys_sector), .phys_wr_o(phys_wr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // downstream ready driver
  always @(posedge clk) begin
    #2;
    phys_ready <= bp_on ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // monitor / scoreboard
  logic [OUT_W-1:0] cur_mask = '0, old_mask = '0;
  bit have_mask = 0;
  bit stall_d = 0;
  logic [OUT_W-1:0] sec_d;
  logic wr_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_d)
        chk(phys_valid && phys_sector == sec_d && phys_wr == wr_d, "R8 stall hold",
            phys_sector, sec_d);
      if (phys_valid && phys_ready) begin
        if (q.size() == 0) chk(1'b0, "R8 unexpected output", phys_sector, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(phys_sector >= BASE && phys_sector < BASE + SPAN, "R2 range", phys_sector, BASE);
          chk(phys_wr == it.wr, "R7 write flag", phys_wr, it.wr);
          if (it.learn) begin
            if (have_mask) chk(phys_sector - BASE != cur_mask, "R3 new mask", phys_sector - BASE, cur_mask);
            old_mask  = cur_mask;
            cur_mask  = phys_sector - BASE;
            have_mask = 1;
          end else begin
            logic [OUT_W-1:0] exp;
            exp = BASE + ({21'b0, it.ls} ^ cur_mask);
            chk(phys_sector == exp, "R1 R5 translation", phys_sector, exp);
          end
        end
      end
      stall_d = phys_valid && !phys_ready;
      sec_d   = phys_sector;
      wr_d    = phys_wr;
    end
  end

  task automatic send(input logic wr, input logic [LOG_W-1:0] ls, input bit learn);
    bit acc;
    req_valid = 1'b1; req_wr = wr; req_sector = ls;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #2;
    end while (!acc);
    q.push_back('{wr: wr, ls: ls, learn: learn});
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic do_restart();
    restart = 1'b1; req_valid = 1'b1; req_sector = 11'h155;
    @(negedge clk);
    chk(req_ready == 1'b0, "R6 hold-off during restart", req_ready, 0);
    @(posedge clk); #2;
    restart = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0 && !phys_valid, "R6 no request taken", q.size(), 0);
    @(posedge clk); #2;
    send(1'b0, '0, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
      end
    join_none

    // R4: reset state
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 && phys_valid == 1'b0, "R4 in reset", {req_ready, phys_valid}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R4 first cycle after reset", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R4 ready after mask", req_ready, 1);
    @(posedge clk); #2;

    // learn reset-session mask, then directed patterns (R1 R7 R5)
    send(1'b0, '0, 1'b1);
    send(1'b1, 11'd2047, 0);
    send(1'b0, 11'd1, 0);
    send(1'b1, 11'd1024, 0);
    send(1'b0, 11'd5, 0);
    send(1'b1, 11'd5, 0);
    for (int i = 0; i < 16; i++) send(1'(i), 11'(i * 131), 0);
    drain();

    // R8 under random backpressure
    bp_on = 1'b1;
    for (int i = 0; i < 60; i++) send(1'($urandom_range(0, 1)), 11'($urandom), 0);
    drain();
    bp_on = 1'b0;

    // R9: full pipeline with stalled output
    @(posedge clk); #2;
    bp_on = 1'b1;
    force phys_ready = 1'b0;
    send(1'b1, 11'd7, 0);
    send(1'b0, 11'd8, 0);
    req_valid = 1'b1; req_sector = 11'd9;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b0, "R9 full pipe stalls input", req_ready, 0);
    @(posedge clk); #2;
    req_valid = 1'b0;
    release phys_ready;
    bp_on = 1'b0;
    drain();

    // restarts at varied spacing (R3 R6 R5)
    for (int r = 0; r < 4; r++) begin
      repeat (3 + r * 7) @(posedge clk);
      #2;
      do_restart();
      send(1'b1, 11'd2047, 0);
      send(1'b0, 11'd300, 0);
      send(1'b1, 11'd300, 0);
      drain();
    end

    finish_run();
  end
endmodule